// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Controller

This block gathers a parameterized set of level-sensitive interrupt lines and presents them to a small group of CPUs. Each line carries a mask bit, a software-trigger bit that is ORed with its hardware input, and a routing word with one bit per CPU. Software controls all of this through a simple 32-bit register bus.

Each CPU has one interrupt output and one event register. The interrupt output is high while any asserted, unmasked line is routed to that CPU. A read of the CPU's event register returns the lowest-numbered such line. The same read also masks that line on the same clock edge, so the read acts as the acknowledge. Software re-enables the line later by writing the mask-clear bank.

Register layout (byte addresses): identification word at 0x000. Mask set and clear banks at 0x100 and 0x180. Software-trigger set and clear banks at 0x200 and 0x280. Per-CPU event registers at 0x300 + 4·cpu. Per-line routing registers at 0x1000 + 4·line. In each bank, word w sits at base + 4·w.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A read of address 0x000 returns the number of lines in bits 15:0 and zero in bits 31:16.
- R2: A write to the mask-set bank sets, and a write to the mask-clear bank clears, the mask of every line whose data bit is 1; zero bits leave their lines unchanged. Word index is line/32 and bit position is line mod 32. A read of either bank returns the current mask word.
- R3: Software-trigger bits have their own set bank (0x200) and clear bank (0x280), laid out as in R2 and read back the same way. A line counts as asserted when its hardware input or its software bit is 1.
- R4: An event read returns type 1 in bits 31:16 and the line number in bits 15:0 when a line is pending for that CPU, and all zeros otherwise. Read data appears on the bus the cycle after the read request.
- R5: When several lines are pending for a CPU, the event read reports the lowest line number.
- R6: An event read that reports a line sets that line's mask bit on the same clock edge. A following event read therefore reports the next pending line.
- R7: Bit c of a line's routing register enables delivery to CPU c. The register reads back with its unused upper bits zero. A line whose bit for a CPU is 0 neither raises that CPU's output nor appears in its event register.
- R8: Each CPU output is high exactly when some asserted, unmasked line is routed to that CPU. It falls right after the event read that masks the last such line.
- R9: After reset, every mask bit is 1, every software bit is 0, and every routing register holds 1 (CPU 0 only).
- R10: Lines are level-sensitive. A hardware input that drops before the event read is not reported.
- R11: Masks are shared across CPUs. A line routed to two CPUs and acknowledged by one is no longer pending for the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_line_i | input | NUM_LINES | Hardware interrupt levels |
| bus_sel_i | input | 1 | Bus access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | NUM_CPUS | Per-CPU interrupt request |

## Verification
The bound checker checks, on every cycle, three things. An event read while a CPU output is high returns a hardware-type word. That word names a line whose mask is set one edge later. An event read while the output is low returns zero. The checker also checks the identification word and the all-masked state after reset. Lowest-number priority, routing isolation between CPUs, shared masks after acknowledgement, and the level behaviour of dropped lines need ordered stimulus. The bench's reference model shows these through its scenarios, and it compares every CPU output to that model on every clock.

// File: rtl/pic_pkg.sv
// Shared definitions for the prioritized interrupt controller.
package pic_pkg;
    // Kind of register-bank update requested by the bus decoder.
    typedef enum logic [2:0] {
        WK_NONE, WK_MSET, WK_MCLR, WK_SSET, WK_SCLR, WK_TGT
    } wr_kind_e;

    // 128-byte pages inside the lower 4 KiB of the map.
    localparam logic [4:0] PG_INFO  = 5'd0;
    localparam logic [4:0] PG_MSET  = 5'd2;
    localparam logic [4:0] PG_MCLR  = 5'd3;
    localparam logic [4:0] PG_SSET  = 5'd4;
    localparam logic [4:0] PG_SCLR  = 5'd5;
    localparam logic [4:0] PG_EVENT = 5'd6;

    localparam logic [15:0] EVT_TYPE_HW = 16'd1;
endpackage

// File: rtl/pic_line_bank.sv
// Per-line state: mask, software trigger and CPU routing.
// Assumes at most one bus update and at most one acknowledge per cycle.
// The acknowledge takes priority over a mask write in the same cycle.
module pic_line_bank
    import pic_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 2,
    parameter int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  wr_kind_e             wr_kind,
    input  logic [9:0]           wr_index,
    input  logic [31:0]          wr_data,
    input  logic                 ack_en,
    input  logic [LINE_W-1:0]    ack_line,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] swt_q,
    output logic [NUM_CPUS-1:0]  tgt_q [NUM_LINES]
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int WORD = i / 32;
        localparam int BIT  = i % 32;
        logic hit_word;
        assign hit_word = (wr_index == 10'(WORD)) && wr_data[BIT];

        // Mask bit: reset set, acknowledge sets, bus sets or clears.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   mask_q[i] <= 1'b1;
            else if (ack_en && ack_line == LINE_W'(i))    mask_q[i] <= 1'b1;
            else if (wr_kind == WK_MSET && hit_word)      mask_q[i] <= 1'b1;
            else if (wr_kind == WK_MCLR && hit_word)      mask_q[i] <= 1'b0;
        end

        // Software trigger bit: bus sets or clears.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   swt_q[i] <= 1'b0;
            else if (wr_kind == WK_SSET && hit_word)      swt_q[i] <= 1'b1;
            else if (wr_kind == WK_SCLR && hit_word)      swt_q[i] <= 1'b0;
        end

        // Routing word: reset to CPU 0, full write from the bus.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tgt_q[i] <= NUM_CPUS'(1);
            else if (wr_kind == WK_TGT && wr_index == 10'(i))
                tgt_q[i] <= wr_data[NUM_CPUS-1:0];
        end
    end
endmodule

// File: rtl/pic_cpu_select.sv
// Lowest-index-first selection of one CPU's pending lines.
// Purely combinational; line is don't-care when any is low.
module pic_cpu_select #(
    parameter int NUM_LINES = 64,
    parameter int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] pend,
    output logic                 any,
    output logic [LINE_W-1:0]    line
);
    // Scan from the top so the lowest set index wins.
    always_comb begin
        line = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--)
            if (pend[i]) line = LINE_W'(i);
        any = |pend;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the auto-masking prioritized interrupt controller.
// Decodes the register bus, forms each CPU's pending set and registers
// read data. An event read acknowledges by masking the reported line.
// Assumes NUM_CPUS <= 32, NUM_LINES <= 1024, ADDR_W > 12.
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_line_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [31:0]          bus_wdata_i,
    output logic [31:0]          bus_rdata_o,
    output logic [NUM_CPUS-1:0]  irq_o
);
    localparam int NUM_WORDS = (NUM_LINES + 31) / 32;
    localparam int LINE_W    = $clog2(NUM_LINES);

    logic [NUM_LINES-1:0] mask_q, swt_q, asserted;
    logic [NUM_CPUS-1:0]  tgt_q [NUM_LINES];
    logic [NUM_LINES-1:0] pend   [NUM_CPUS];
    logic [LINE_W-1:0]    cpu_line [NUM_CPUS];
    logic [NUM_CPUS-1:0]  cpu_any;

    logic       in_tgt;
    logic [4:0] page, idx;
    logic [9:0] tline;
    wr_kind_e   wr_kind;
    logic       ack_en;
    logic [LINE_W-1:0] ack_line;
    logic [31:0] rd_val;

    // Address fields.
    assign in_tgt = bus_addr_i[ADDR_W-1:12] == (ADDR_W-12)'(1);
    assign page   = bus_addr_i[11:7];
    assign idx    = bus_addr_i[6:2];
    assign tline  = bus_addr_i[11:2];

    assign asserted = irq_line_i | swt_q;

    pic_line_bank #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .LINE_W(LINE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_kind(wr_kind),
        .wr_index(in_tgt ? tline : {5'd0, idx}), .wr_data(bus_wdata_i),
        .ack_en(ack_en), .ack_line(ack_line),
        .mask_q(mask_q), .swt_q(swt_q), .tgt_q(tgt_q)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        // Pending set for this CPU: asserted, unmasked, routed here.
        always_comb
            for (int i = 0; i < NUM_LINES; i++)
                pend[c][i] = asserted[i] && !mask_q[i] && tgt_q[i][c];

        pic_cpu_select #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_sel (
            .pend(pend[c]), .any(cpu_any[c]), .line(cpu_line[c])
        );
        assign irq_o[c] = cpu_any[c];
    end

    // Write decode into a bank update kind.
    always_comb begin
        wr_kind = WK_NONE;
        if (bus_sel_i && bus_wr_i) begin
            if (in_tgt) begin
                if (tline < 10'(NUM_LINES)) wr_kind = WK_TGT;
            end else if (idx < 5'(NUM_WORDS)) begin
                case (page)
                    PG_MSET: wr_kind = WK_MSET;
                    PG_MCLR: wr_kind = WK_MCLR;
                    PG_SSET: wr_kind = WK_SSET;
                    PG_SCLR: wr_kind = WK_SCLR;
                    default: wr_kind = WK_NONE;
                endcase
            end
        end
    end

    // Event-read acknowledge: pick the addressed CPU's winning line.
    always_comb begin
        ack_en   = 1'b0;
        ack_line = '0;
        if (bus_sel_i && !bus_wr_i && !in_tgt && page == PG_EVENT)
            for (int c = 0; c < NUM_CPUS; c++)
                if (idx == 5'(c) && cpu_any[c]) begin
                    ack_en   = 1'b1;
                    ack_line = cpu_line[c];
                end
    end

    // Read mux over all readable registers.
    always_comb begin
        rd_val = '0;
        if (in_tgt) begin
            for (int i = 0; i < NUM_LINES; i++)
                if (tline == 10'(i)) rd_val = 32'(tgt_q[i]);
        end else begin
            case (page)
                PG_INFO: if (idx == 5'd0) rd_val = 32'(NUM_LINES);
                PG_MSET, PG_MCLR:
                    for (int b = 0; b < NUM_WORDS * 32; b++)
                        if (b < NUM_LINES && idx == 5'(b / 32)) rd_val[b % 32] = mask_q[b];
                PG_SSET, PG_SCLR:
                    for (int b = 0; b < NUM_WORDS * 32; b++)
                        if (b < NUM_LINES && idx == 5'(b / 32)) rd_val[b % 32] = swt_q[b];
                PG_EVENT:
                    for (int c = 0; c < NUM_CPUS; c++)
                        if (idx == 5'(c) && cpu_any[c])
                            rd_val = {EVT_TYPE_HW, 16'(cpu_line[c])};
                default: rd_val = '0;
            endcase
        end
    end

    // Read data register, loaded on the same edge as any acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                       bus_rdata_o <= '0;
        else if (bus_sel_i && !bus_wr_i)  bus_rdata_o <= rd_val;
    end
endmodule

// File: rtl/pic_checker.sv
// Temporal checks for prio_irq_ctrl, attached by bind.
// Observes bus ports, CPU outputs and the line bank's mask state.
module pic_checker #(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel_i,
    input logic                 bus_wr_i,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic [31:0]          bus_rdata_o,
    input logic [NUM_CPUS-1:0]  irq_o,
    input logic [NUM_LINES-1:0] mask_q
);
    localparam int LINE_W = $clog2(NUM_LINES);
    logic info_rd;
    assign info_rd = bus_sel_i && !bus_wr_i && bus_addr_i == '0;

    // R1: identification word.
    a_r1_info_word: assert property (@(posedge clk) disable iff (!rst_n)
        info_rd |=> bus_rdata_o == 32'(NUM_LINES));

    // R9: all masks set right after reset release.
    a_r9_reset_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> &mask_q);

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic ev_rd;
        assign ev_rd = bus_sel_i && !bus_wr_i && bus_addr_i == ADDR_W'(32'h300 + 4 * c);

        // R4: pending CPU gets a hardware-type word naming a real line.
        a_r4_event_word: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_rd && irq_o[c]) |=> (bus_rdata_o[31:16] == 16'd1 &&
                                     bus_rdata_o[15:0] < 16'(NUM_LINES)));

        // R4: idle CPU reads zero.
        a_r4_event_empty: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_rd && !irq_o[c]) |=> bus_rdata_o == 32'd0);

        // R6: the reported line is masked after the read.
        a_r6_read_masks: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_rd && irq_o[c]) |=> mask_q[bus_rdata_o[LINE_W-1:0]]);
    end
endmodule

bind prio_irq_ctrl pic_checker #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .mask_q(mask_q)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    localparam int NL = 64;
    localparam int NC = 2;

    logic        clk = 0, rst_n = 0;
    logic [NL-1:0] hw = '0;
    logic        sel = 0, wr = 0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NC-1:0] irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model state
    bit m_mask [NL];
    bit m_sw   [NL];
    bit [NC-1:0] m_tgt [NL];

    prio_irq_ctrl #(.NUM_LINES(NL), .NUM_CPUS(NC), .ADDR_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .irq_line_i(hw), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    always #4 clk = ~clk;

    function automatic int exp_line(int c);
        for (int i = 0; i < NL; i++)
            if ((hw[i] || m_sw[i]) && !m_mask[i] && m_tgt[i][c]) return i;
        return -1;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle output comparison against the model (R8).
    always @(posedge clk) begin
        #2;
        if (rst_n && !done)
            for (int c = 0; c < NC; c++)
                check(irq[c] == (exp_line(c) >= 0), "R8 irq level", 32'(irq[c]),
                      32'(exp_line(c) >= 0));
    end

    task automatic wr_reg(logic [15:0] a, logic [31:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
        @(posedge clk);
        if (a >= 16'h1000) begin
            if ((a - 16'h1000) / 4 < NL) m_tgt[(a - 16'h1000) / 4] = d[NC-1:0];
        end else begin
            for (int b = 0; b < 32; b++) begin
                int l = ((a & 16'h7f) / 4) * 32 + b;
                if (d[b] && l < NL)
                    case (a & 16'hf80)
                        16'h100: m_mask[l] = 1;
                        16'h180: m_mask[l] = 0;
                        16'h200: m_sw[l] = 1;
                        16'h280: m_sw[l] = 0;
                        default: ;
                    endcase
            end
        end
        #1 sel = 0; wr = 0;
    endtask

    task automatic rd_chk(logic [15:0] a, logic [31:0] exp, string req);
        @(negedge clk); sel = 1; wr = 0; addr = a;
        @(posedge clk);
        #2 check(rdata === exp, req, rdata, exp);
        sel = 0;
    endtask

    task automatic ev_chk(int c, string req);
        int l;
        logic [31:0] exp;
        @(negedge clk); sel = 1; wr = 0; addr = 16'(16'h300 + 4 * c);
        @(posedge clk);
        l = exp_line(c);
        exp = (l >= 0) ? {16'd1, 16'(l)} : 32'd0;
        if (l >= 0) m_mask[l] = 1;
        #2 check(rdata === exp, req, rdata, exp);
        sel = 0;
    endtask

    task automatic set_hw(int l, bit v);
        @(negedge clk); hw[l] = v;
    endtask

    initial begin
        for (int i = 0; i < NL; i++) begin m_mask[i] = 1; m_sw[i] = 0; m_tgt[i] = 1; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // Reset state and identification
        rd_chk(16'h000, 32'd64, "R1 info");
        rd_chk(16'h100, 32'hffff_ffff, "R9 mask word0");
        rd_chk(16'h184, 32'hffff_ffff, "R9 mask word1");
        rd_chk(16'h204, 32'h0, "R9 sw word1");
        rd_chk(16'h1000 + 4 * 63, 32'h1, "R9 target");
        ev_chk(0, "R4 empty event");

        // Priority and auto-mask
        wr_reg(16'h180, 32'h0000_0020);          // unmask line 5
        wr_reg(16'h184, 32'h8000_0100);          // unmask lines 40, 63
        rd_chk(16'h104, 32'h7fff_feff, "R2 mask word1 readback");
        set_hw(40, 1); set_hw(5, 1);
        ev_chk(0, "R5 lowest first");
        rd_chk(16'h100, 32'hffff_ffff, "R6 line5 remasked");
        ev_chk(0, "R6 next line");
        ev_chk(0, "R8 drained event zero");
        set_hw(5, 0); set_hw(40, 0);

        // Software trigger
        wr_reg(16'h204, 32'h8000_0000);
        rd_chk(16'h284, 32'h8000_0000, "R3 sw readback");
        ev_chk(0, "R3 sw line 63");
        wr_reg(16'h184, 32'h8000_0000);
        wr_reg(16'h284, 32'h8000_0000);
        ev_chk(0, "R3 sw cleared");
        // Mask set bank on an unmasked hardware line
        wr_reg(16'h180, 32'h0000_0008);
        set_hw(3, 1);
        wr_reg(16'h100, 32'h0000_0008);
        ev_chk(0, "R2 mask set blocks");
        set_hw(3, 0);

        // Routing
        wr_reg(16'h1000 + 4 * 10, 32'hffff_fffe);
        rd_chk(16'h1000 + 4 * 10, 32'h2, "R7 target readback");
        wr_reg(16'h180, 32'h0000_0400);
        set_hw(10, 1);
        ev_chk(0, "R7 cpu0 not routed");
        ev_chk(1, "R7 cpu1 routed");
        set_hw(10, 0);

        // Shared mask across CPUs
        wr_reg(16'h1000 + 4 * 20, 32'h3);
        wr_reg(16'h180, 32'h0010_0000);
        set_hw(20, 1);
        ev_chk(1, "R11 cpu1 acks");
        ev_chk(0, "R11 cpu0 sees none");
        set_hw(20, 0);

        // Level behaviour
        wr_reg(16'h180, 32'h0000_0080);
        set_hw(7, 1);
        set_hw(7, 0);
        ev_chk(0, "R10 dropped level");

        repeat (3) @(posedge clk);
        done = 1;
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule